// File: doc/BRIEF.md
# Second-Operand Barrel Shifter

This block conditions the second source operand of a data-processing operation before it reaches the ALU. The first operand never passes through it. It takes a word, a shift kind, a shift distance and the current status carry. It returns the conditioned word and a shifter carry, which logical operations write into the status carry. The block is purely combinational and sits between the operand read and the ALU input.

The core is a logarithmic chain of right-shifting stages. Left shifts use the same chain by mirroring the word on the way in and on the way out. A rotate-through-carry kind puts the incoming carry above the sign bit and treats the whole as a 33-bit ring. Distances from 0 to WIDTH-1 are supported. Larger distances and the packed immediate-rotate form belong to other logic.

Kind encodings on `kind_i`: 3'd0 logical left, 3'd1 logical right, 3'd2 arithmetic right, 3'd3 rotate right, 3'd4 rotate right through carry, 3'd5 arithmetic left, 3'd6 and 3'd7 reserved.

Top module: `op2_shifter`

## Requirements
- R1: Kind 3'd0 (logical left) by n>0 gives operand<<n with zeros in the low n bits, and the carry is operand bit WIDTH-n.
- R2: Kind 3'd1 (logical right) by n>0 gives operand>>n with zeros in the top n bits, and the carry is operand bit n-1.
- R3: Kind 3'd2 (arithmetic right) by n>0 fills the top n bits with the original bit WIDTH-1, and the carry is operand bit n-1.
- R4: Kind 3'd3 (rotate right) by n>0 moves bits leaving bit 0 into bit WIDTH-1, keeps the count of ones, and the carry is operand bit n-1.
- R5: Kind 3'd4 (rotate through carry) ignores the distance, gives {carry_i, operand[WIDTH-1:1]}, and the carry out is operand bit 0.
- R6: A distance of 0 with any kind except 3'd4 passes the operand unchanged, and the carry out equals carry_i.
- R7: Kind 3'd5 (arithmetic left) gives the same result and carry as kind 3'd0 for every operand and distance.
- R8: Reserved kinds 3'd6 and 3'd7 pass the operand unchanged, and the carry out equals carry_i.
- R9: For every kind except 3'd4, carry_i has no effect on result_o.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| operand_i | input | WIDTH | Second source operand |
| kind_i | input | 3 | Shift kind code |
| amt_i | input | $clog2(WIDTH) | Shift distance, 0 to WIDTH-1 |
| carry_i | input | 1 | Current status carry |
| result_o | output | WIDTH | Conditioned operand |
| carry_o | output | 1 | Shifter carry out |

## Verification
The carry is hardest to get right at the ends of the distance range. At distance 1 and distance WIDTH-1 it comes from bit 0, bit 1, bit WIDTH-2 or bit WIDTH-1, depending on the direction. The carry-out mux and the mirrored left path only show a defect on operands whose bits differ at exactly those positions. The stimulus therefore runs every kind over both end distances with sparse operands such as 0x80000001 and 0x40000002, and with all-ones operands and their complements. It then sweeps a pseudo-random walk over kinds, distances and carry values. Each distance-0 vector and each reserved-kind vector is applied twice, once with each carry_i value, so that the pass-through carry and R9 are both exercised.

// File: rtl/hsh_pkg.sv
package hsh_pkg;

   typedef enum logic [2:0] {
      HSH_LSL = 3'd0,
      HSH_LSR = 3'd1,
      HSH_ASR = 3'd2,
      HSH_ROR = 3'd3,
      HSH_RRX = 3'd4,
      HSH_ASL = 3'd5,
      HSH_RS6 = 3'd6,
      HSH_RS7 = 3'd7
   } hsh_kind_e;

   // decoded control for the datapath
   typedef struct packed {
      logic mirror;   // left shift: run the right-shift chain on the mirrored word
      logic rotate;   // stages recirculate instead of filling
      logic arith;    // fill with the sign bit
      logic through;  // 33-bit rotate through carry
      logic bypass;   // result is the operand unchanged
      logic leftc;    // carry comes from the upper side
   } hsh_ctl_t;

endpackage

// File: rtl/hsh_decode.sv
module hsh_decode
   import hsh_pkg::*;
#(
   parameter int AMT_W = 5
) (
   input  logic [2:0]       kind_i,
   input  logic [AMT_W-1:0] amt_i,
   output hsh_ctl_t         ctl_o
);

   hsh_kind_e kind;
   logic      amt_zero;

   assign kind     = hsh_kind_e'(kind_i);
   assign amt_zero = (amt_i == '0);

   always_comb begin
      ctl_o = '0;
      unique case (kind)
         HSH_LSL, HSH_ASL: begin
            ctl_o.mirror = 1'b1;
            ctl_o.leftc  = 1'b1;
            ctl_o.bypass = amt_zero;
         end
         HSH_LSR: ctl_o.bypass = amt_zero;
         HSH_ASR: begin
            ctl_o.arith  = 1'b1;
            ctl_o.bypass = amt_zero;
         end
         HSH_ROR: begin
            ctl_o.rotate = 1'b1;
            ctl_o.bypass = amt_zero;
         end
         HSH_RRX: ctl_o.through = 1'b1;
         default: ctl_o.bypass = 1'b1;
      endcase
   end

endmodule

// File: rtl/hsh_stage.sv
module hsh_stage #(
   parameter int WIDTH = 32,
   parameter int DIST  = 1
) (
   input  logic [WIDTH-1:0] d_i,
   input  logic             en_i,
   input  logic             rot_i,
   input  logic             fill_i,
   output logic [WIDTH-1:0] q_o
);

   logic [DIST-1:0] top;

   assign top = rot_i ? d_i[DIST-1:0] : {DIST{fill_i}};
   assign q_o = en_i ? {top, d_i[WIDTH-1:DIST]} : d_i;

endmodule

// File: rtl/hsh_carry.sv
module hsh_carry
   import hsh_pkg::*;
#(
   parameter int WIDTH = 32,
   parameter int AMT_W = 5
) (
   input  logic [WIDTH-1:0] operand_i,
   input  logic [AMT_W-1:0] amt_i,
   input  hsh_ctl_t         ctl_i,
   input  logic             carry_i,
   output logic             carry_o
);

   logic [AMT_W-1:0] idx_lo;
   logic [AMT_W-1:0] idx_hi;

   // right kinds lose bit n-1 last; left kinds lose bit WIDTH-n last
   assign idx_lo = amt_i - AMT_W'(1);
   assign idx_hi = AMT_W'(0) - amt_i;

   always_comb begin
      if (ctl_i.through)     carry_o = operand_i[0];
      else if (ctl_i.bypass) carry_o = carry_i;
      else if (ctl_i.leftc)  carry_o = operand_i[idx_hi];
      else                   carry_o = operand_i[idx_lo];
   end

endmodule

// File: rtl/op2_shifter.sv
module op2_shifter
   import hsh_pkg::*;
#(
   parameter int WIDTH = 32,
   parameter int AMT_W = $clog2(WIDTH)
) (
   input  logic [WIDTH-1:0] operand_i,
   input  logic [2:0]       kind_i,
   input  logic [AMT_W-1:0] amt_i,
   input  logic             carry_i,
   output logic [WIDTH-1:0] result_o,
   output logic             carry_o
);

   localparam int NSTAGE = AMT_W;

   generate
      if (WIDTH < 2 || (WIDTH & (WIDTH - 1)) != 0)
         $error("op2_shifter: WIDTH must be a power of two of at least 2");
      if (AMT_W != $clog2(WIDTH))
         $error("op2_shifter: AMT_W must equal clog2(WIDTH)");
   endgenerate

   hsh_ctl_t ctl;

   hsh_decode #(.AMT_W(AMT_W)) u_dec (
      .kind_i (kind_i),
      .amt_i  (amt_i),
      .ctl_o  (ctl)
   );

   logic [WIDTH-1:0] mir_in;
   logic [WIDTH-1:0] mir_out;
   logic [WIDTH-1:0] chain_out;
   logic [WIDTH-1:0] through_val;
   logic             fill;
   logic [NSTAGE:0][WIDTH-1:0] lvl;

   // mirrored copies let the left shift reuse the right-shift stages
   genvar b;
   generate
      for (b = 0; b < WIDTH; b++) begin : g_mirror
         assign mir_in[b]  = operand_i[WIDTH-1-b];
         assign mir_out[b] = lvl[NSTAGE][WIDTH-1-b];
      end
   endgenerate

   assign fill   = ctl.arith & operand_i[WIDTH-1];
   assign lvl[0] = ctl.mirror ? mir_in : operand_i;

   genvar k;
   generate
      for (k = 0; k < NSTAGE; k++) begin : g_stage
         hsh_stage #(.WIDTH(WIDTH), .DIST(1 << k)) u_stg (
            .d_i    (lvl[k]),
            .en_i   (amt_i[k]),
            .rot_i  (ctl.rotate),
            .fill_i (fill),
            .q_o    (lvl[k+1])
         );
      end
   endgenerate

   assign chain_out   = ctl.mirror ? mir_out : lvl[NSTAGE];
   assign through_val = {carry_i, operand_i[WIDTH-1:1]};

   always_comb begin
      if (ctl.through)     result_o = through_val;
      else if (ctl.bypass) result_o = operand_i;
      else                 result_o = chain_out;
   end

   hsh_carry #(.WIDTH(WIDTH), .AMT_W(AMT_W)) u_cy (
      .operand_i (operand_i),
      .amt_i     (amt_i),
      .ctl_i     (ctl),
      .carry_i   (carry_i),
      .carry_o   (carry_o)
   );

endmodule

// File: rtl/op2_shifter_chk.sv
module op2_shifter_chk #(
   parameter int WIDTH = 32,
   parameter int AMT_W = $clog2(WIDTH)
) (
   input logic [WIDTH-1:0] operand_i,
   input logic [2:0]       kind_i,
   input logic [AMT_W-1:0] amt_i,
   input logic             carry_i,
   input logic [WIDTH-1:0] result_o,
   input logic             carry_o
);

   logic [WIDTH-1:0] low_mask;
   logic [WIDTH-1:0] high_part;
   logic [WIDTH-1:0] sign_diff;
   int               n;

   always_comb begin
      n         = int'(amt_i);
      low_mask  = (WIDTH'(1) << n) - WIDTH'(1);
      high_part = result_o >> (WIDTH - n);
      sign_diff = (result_o ^ {WIDTH{operand_i[WIDTH-1]}}) >> (WIDTH - n);
   end

   always_comb begin
      if (n != 0 && kind_i == 3'd0)
         AST_LSL_LOW_ZERO: assert ((result_o & low_mask) == '0);          // R1
      if (n != 0 && kind_i == 3'd1)
         AST_LSR_HIGH_ZERO: assert (high_part == '0);                     // R2
      if (n != 0 && kind_i == 3'd2)
         AST_ASR_SIGN_FILL: assert (sign_diff == '0);                     // R3
      if (n != 0 && kind_i == 3'd3)
         AST_ROR_ONES_KEPT: assert ($countones(result_o) == $countones(operand_i) && carry_o == result_o[WIDTH-1]); // R4
      if (kind_i == 3'd4)
         AST_RRX_RING: assert (result_o[WIDTH-1] == carry_i && carry_o == operand_i[0]); // R5
      if (n == 0 && kind_i != 3'd4)
         AST_ZERO_DIST_PASS: assert (result_o == operand_i && carry_o == carry_i); // R6
      if (kind_i[2:1] == 2'b11)
         AST_RESERVED_PASS: assert (result_o == operand_i && carry_o == carry_i); // R8
   end

endmodule

bind op2_shifter op2_shifter_chk #(.WIDTH(WIDTH), .AMT_W(AMT_W)) u_chk (
   .operand_i (operand_i),
   .kind_i    (kind_i),
   .amt_i     (amt_i),
   .carry_i   (carry_i),
   .result_o  (result_o),
   .carry_o   (carry_o)
);

// File: tb/sim_op2_shifter.sv
module sim_op2_shifter;

   localparam int W  = 32;
   localparam int AW = 5;

   typedef struct {
      logic [W-1:0] res;
      logic         cy;
      string        tag;
   } exp_t;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [W-1:0]  operand;
   logic [2:0]    kind;
   logic [AW-1:0] amt;
   logic          cin;
   logic [W-1:0]  result;
   logic          cout;

   int   n_vec  = 0;
   int   n_fail = 0;
   bit   done   = 1'b0;
   exp_t sb[$];

   always #4 clk = ~clk;   // 125 MHz

   op2_shifter #(.WIDTH(W)) u0 (
      .operand_i (operand),
      .kind_i    (kind),
      .amt_i     (amt),
      .carry_i   (cin),
      .result_o  (result),
      .carry_o   (cout)
   );

   // reference model written from the requirements; returns {carry, value}
   function automatic logic [W:0] model(logic [W-1:0] v, logic [2:0] k, int n, logic c);
      logic [W-1:0] r;
      if (k == 3'd4) return {v[0], c, v[W-1:1]};
      if (k[2:1] == 2'b11 || n == 0) return {c, v};
      case (k)
         3'd0, 3'd5: return {v[W-n], v << n};
         3'd1:       return {v[n-1], v >> n};
         3'd2: begin
            r = W'($signed(v) >>> n);
            return {v[n-1], r};
         end
         default:    return {v[n-1], (v >> n) | (v << (W - n))};
      endcase
   endfunction

   function automatic string tag_of(logic [2:0] k, int n);
      if (k == 3'd4) return "R5";
      if (k[2:1] == 2'b11) return "R8";
      if (n == 0) return "R6";
      case (k)
         3'd0: return "R1";
         3'd1: return "R2";
         3'd2: return "R3";
         3'd3: return "R4";
         default: return "R7";
      endcase
   endfunction

   task automatic apply(logic [W-1:0] v, logic [2:0] k, int n, logic c, string tg);
      logic [W:0] e;
      exp_t       it;
      @(negedge clk);
      operand = v; kind = k; amt = AW'(n); cin = c;
      e      = model(v, k, n, c);
      it.res = e[W-1:0];
      it.cy  = e[W];
      it.tag = (tg == "") ? tag_of(k, n) : tg;
      sb.push_back(it);
   endtask

   // monitor: compares half a cycle after each vector was driven
   always @(posedge clk) begin
      if (rst_n && sb.size() > 0) begin
         exp_t it;
         it = sb.pop_front();
         n_vec++;
         if (result !== it.res || cout !== it.cy) begin
            n_fail++;
            $display("FAIL %s: kind=%0d amt=%0d cin=%0b op=%h got res=%h cy=%0b exp res=%h cy=%0b",
                     it.tag, kind, amt, cin, operand, result, cout, it.res, it.cy);
         end
      end
   end

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: got hang, exp completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
         $finish;
      end
   end

   initial begin : stim
      logic [W-1:0] lfsr;
      logic [W-1:0] pats [6];
      operand = '0; kind = 3'd0; amt = '0; cin = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // reset state: all-zero inputs give zero result and carry (R6)
      apply('0, 3'd0, 0, 1'b0, "R6");
      pats[0] = 32'h8000_0001; pats[1] = 32'h4000_0002; pats[2] = 32'hFFFF_FFFF;
      pats[3] = 32'h7FFF_FFFF; pats[4] = 32'hBFFF_FFFD; pats[5] = 32'h1234_5678;
      // end-of-range distances for every kind, both carry values
      for (int p = 0; p < 6; p++)
         for (int k = 0; k < 8; k++)
            for (int d = 0; d < 4; d++)
               for (int c = 0; c < 2; c++) begin
                  int n;
                  n = (d == 0) ? 0 : (d == 1) ? 1 : (d == 2) ? 30 : 31;
                  apply(pats[p], 3'(k), n, 1'(c), "");
               end
      // R7: arithmetic left against logical left expectation, every distance
      for (int n = 0; n < 32; n++) apply(32'hC3A5_0F69, 3'd5, n, 1'b1, "R7");
      // R9: carry_i must not change the value for non-through kinds
      for (int n = 1; n < 32; n += 5) begin
         apply(32'h9E37_79B9, 3'd1, n, 1'b0, "R9");
         apply(32'h9E37_79B9, 3'd1, n, 1'b1, "R9");
         apply(32'h9E37_79B9, 3'd3, n, 1'b1, "R9");
      end
      // pseudo-random sweep
      lfsr = 32'hACE1_1357;
      for (int i = 0; i < 3000; i++) begin
         lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
         apply(lfsr, lfsr[2:0], int'(lfsr[9:5]), lfsr[12], "");
      end
      @(negedge clk);
      @(negedge clk);
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
   end

endmodule